// File: doc/BRIEF.md
# Two-Level Lookahead Binary Adder

This block is a purely combinational binary adder for wide datapaths such as the integrator chain of a multi-stage decimation filter. It splits its operands into four-bit slices. Each slice forms a propagate and a generate term for every bit. It computes its own internal carries from fully expanded lookahead equations and reports one group propagate and one group generate term to a second-level lookahead unit. That unit derives the carry entering every slice directly from the group terms and the carry input. Carries therefore never ripple bit by bit, and never pass from one slice's carry output into the next slice.

The operand width is a parameter. The intended range is 8 to 25 bits, which covers the 25, 22, 20, 18 and 16 bit integrator widths. When the width is not a multiple of four, the top slice is filled with zero bits. The sum bits of the filled positions are discarded, and the carry output is taken from the most significant real bit.

Top module: `cla_adder`

## Requirements
- R1: `sum_out` equals the low WIDTH bits of `add_a + add_b + carry_in`, evaluated combinationally.
- R2: `carry_out` equals bit WIDTH of `add_a + add_b + carry_in`. This is the carry out of operand bit WIDTH-1.
- R3: With every bit propagating (`add_a` all ones, `add_b` zero), `carry_out` equals `carry_in`, and `sum_out` is all ones when `carry_in` is 0 and all zeros when it is 1.
- R4: A carry generated in the top bit of a slice reaches the next slice. For example, at 8 bits, 0x0F + 0x01 gives 0x10 with `carry_out` 0. Each slice's carry input equals the true carry out of the slice below it.
- R5: Inside a slice, a group propagate of 1 passes the slice carry input unchanged to its carry output, and a group generate of 1 forces that carry output to 1.
- R6: The adder is correct for WIDTH of 8, 16, 18, 20, 22 and 25. At 8 bits every pair of operands is correct with both carry input values.
- R7: For a WIDTH that is not a multiple of 4, the padding bits contribute no carry. With all-ones operands, `carry_out` is set from the top real bit; for example, at 22 bits, 0x3FFFFF + 1 gives sum 0 and `carry_out` 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| add_a | input | WIDTH | First operand |
| add_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Sum, low WIDTH bits |
| carry_out | output | 1 | Carry out of bit WIDTH-1 |

## Verification
The hardest case to reach is a carry that crosses every slice boundary and ends in a partially filled top slice. Random operands almost never make all bits propagate at 22 or 25 bits. The stimulus therefore applies all-ones operands with both carry inputs directly at each padded width, alongside exhaustive 8-bit coverage and random vectors at the wider widths.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int SLICE_W = 4;

  function automatic int slice_count(input int width);
    return (width + SLICE_W - 1) / SLICE_W;
  endfunction
endpackage

// File: rtl/cla_slice4.sv
module cla_slice4 (
  input  logic [3:0] op_a,
  input  logic [3:0] op_b,
  input  logic       c_in,
  output logic [3:0] sum,
  output logic [3:0] c_up,
  output logic       grp_p,
  output logic       grp_g
);
  logic [3:0] p;
  logic [3:0] g;
  logic [3:0] c_low;

  always_comb begin
    p = op_a ^ op_b;
    g = op_a & op_b;
    c_up[0] = g[0] | (p[0] & c_in);
    c_up[1] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & c_in);
    c_up[2] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
            | (p[2] & p[1] & p[0] & c_in);
    c_up[3] = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
            | (p[3] & p[2] & p[1] & g[0]) | (p[3] & p[2] & p[1] & p[0] & c_in);
    grp_p = p[3] & p[2] & p[1] & p[0];
    grp_g = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
          | (p[3] & p[2] & p[1] & g[0]);
    c_low = {c_up[2:0], c_in};
    sum = p ^ c_low;
  end

  always_comb begin
    // R5
    grp_pass_chk: assert (!grp_p || (c_up[3] == c_in));
    // R5
    grp_gen_chk: assert (!grp_g || c_up[3]);
  end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int NG = 7
) (
  input  logic [NG-1:0] gp,
  input  logic [NG-1:0] gg,
  input  logic          c_in,
  output logic [NG:0]   gc
);
  always_comb begin
    gc[0] = c_in;
    for (int k = 1; k <= NG; k++) begin
      logic acc;
      logic chain;
      chain = c_in;
      for (int i = 0; i < k; i++) chain = chain & gp[i];
      acc = chain;
      for (int j = 0; j < k; j++) begin
        logic term;
        term = gg[j];
        for (int i = j + 1; i < k; i++) term = term & gp[i];
        acc = acc | term;
      end
      gc[k] = acc;
    end
  end
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int WIDTH = 25
) (
  input  logic [WIDTH-1:0] add_a,
  input  logic [WIDTH-1:0] add_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);
  import cla_pkg::*;

  localparam int NG   = slice_count(WIDTH);
  localparam int PW   = NG * SLICE_W;
  localparam int TOPB = WIDTH - SLICE_W * (NG - 1);

  logic [PW-1:0] a_pad;
  logic [PW-1:0] b_pad;
  logic [PW-1:0] s_pad;
  logic [NG-1:0] gp;
  logic [NG-1:0] gg;
  logic [NG:0]   gc;
  logic [3:0]    sl_c [NG];

  assign a_pad = PW'(add_a);
  assign b_pad = PW'(add_b);

  cla_lookahead #(.NG(NG)) la_i (
    .gp   (gp),
    .gg   (gg),
    .c_in (carry_in),
    .gc   (gc)
  );

  for (genvar s = 0; s < NG; s++) begin : g_slice
    cla_slice4 sl_i (
      .op_a  (a_pad[s*SLICE_W +: SLICE_W]),
      .op_b  (b_pad[s*SLICE_W +: SLICE_W]),
      .c_in  (gc[s]),
      .sum   (s_pad[s*SLICE_W +: SLICE_W]),
      .c_up  (sl_c[s]),
      .grp_p (gp[s]),
      .grp_g (gg[s])
    );
  end

  assign sum_out   = s_pad[WIDTH-1:0];
  assign carry_out = sl_c[NG-1][TOPB-1];

  always_comb begin
    // R1
    sum_match_chk: assert ({carry_out, sum_out} ==
                           (({1'b0, add_a} + {1'b0, add_b}) + (WIDTH+1)'(carry_in)));
    for (int k = 1; k <= NG; k++) begin
      // R4
      carry_agree_chk: assert (gc[k] == sl_c[k-1][3]);
    end
    for (int i = WIDTH; i < PW; i++) begin
      // R7
      pad_sum_chk: assert (s_pad[i] == ((i == WIDTH) ? carry_out : 1'b0));
    end
  end
endmodule

// File: tb/cla_adder_tb.sv
module cla_adder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 195000;
  localparam int NRAND      = 2000;
  localparam int NTBL       = 8;
  // entry = {a[7:0], b[7:0], cin, sum[7:0], cout}
  localparam logic [25:0] TBL [NTBL] = '{
    {8'h00, 8'h00, 1'b0, 8'h00, 1'b0},
    {8'hFF, 8'h01, 1'b0, 8'h00, 1'b1},
    {8'hFF, 8'h00, 1'b1, 8'h00, 1'b1},
    {8'h0F, 8'h01, 1'b0, 8'h10, 1'b0},
    {8'h80, 8'h80, 1'b0, 8'h00, 1'b1},
    {8'hAA, 8'h55, 1'b0, 8'hFF, 1'b0},
    {8'hAA, 8'h55, 1'b1, 8'h00, 1'b1},
    {8'h7F, 8'h7F, 1'b1, 8'hFF, 1'b0}
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] a_v = '0;
  logic [31:0] b_v = '0;
  logic        cin_v = 1'b0;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [24:0] s25; logic c25;
  logic [21:0] s22; logic c22;
  logic [19:0] s20; logic c20;
  logic [17:0] s18; logic c18;
  logic [15:0] s16; logic c16;
  logic [7:0]  s8;  logic c8;

  cla_adder #(.WIDTH(25)) dut_i (.add_a(a_v[24:0]), .add_b(b_v[24:0]), .carry_in(cin_v), .sum_out(s25), .carry_out(c25));
  cla_adder #(.WIDTH(22)) w22_i (.add_a(a_v[21:0]), .add_b(b_v[21:0]), .carry_in(cin_v), .sum_out(s22), .carry_out(c22));
  cla_adder #(.WIDTH(20)) w20_i (.add_a(a_v[19:0]), .add_b(b_v[19:0]), .carry_in(cin_v), .sum_out(s20), .carry_out(c20));
  cla_adder #(.WIDTH(18)) w18_i (.add_a(a_v[17:0]), .add_b(b_v[17:0]), .carry_in(cin_v), .sum_out(s18), .carry_out(c18));
  cla_adder #(.WIDTH(16)) w16_i (.add_a(a_v[15:0]), .add_b(b_v[15:0]), .carry_in(cin_v), .sum_out(s16), .carry_out(c16));
  cla_adder #(.WIDTH(8))  w8_i  (.add_a(a_v[7:0]),  .add_b(b_v[7:0]),  .carry_in(cin_v), .sum_out(s8),  .carry_out(c8));

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic c);
    @(posedge clk);
    #1;
    a_v = a; b_v = b; cin_v = c;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int w, input logic [31:0] got_s, input logic got_c);
    logic [32:0] msk;
    logic [32:0] full;
    msk  = (33'd1 << w) - 33'd1;
    full = (33'(a_v) & msk) + (33'(b_v) & msk) + 33'(cin_v);
    total++;
    if ((33'(got_s) != (full & msk)) || (got_c != full[w])) begin
      bad++;
      $display("FAIL %s w=%0d a=%h b=%h cin=%0d got sum=%h cout=%0d exp sum=%h cout=%0d",
               req, w, a_v, b_v, cin_v, got_s, got_c, full & msk, full[w]);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, 25, 32'(s25), c25);
    chk(req, 22, 32'(s22), c22);
    chk(req, 20, 32'(s20), c20);
    chk(req, 18, 32'(s18), c18);
    chk(req, 16, 32'(s16), c16);
    chk(req, 8,  32'(s8),  c8);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // idle state, zero operands: R1 R2
    drive('0, '0, 1'b0);
    chk_all("R1 idle");

    // table walk at 8 bits: R1 R2 R4
    for (int i = 0; i < NTBL; i++) begin
      drive(32'(TBL[i][25:18]), 32'(TBL[i][17:10]), TBL[i][9]);
      total++;
      if ((s8 != TBL[i][8:1]) || (c8 != TBL[i][0])) begin
        bad++;
        $display("FAIL R4 table %0d got sum=%h cout=%0d exp sum=%h cout=%0d",
                 i, s8, c8, TBL[i][8:1], TBL[i][0]);
      end
    end

    // exhaustive 8-bit: R6
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        for (int c = 0; c < 2; c++) begin
          drive(32'(a), 32'(b), c[0]);
          chk("R6 exhaustive8", 8, 32'(s8), c8);
        end
      end
    end

    // random wide operands: R1 R2 R6
    for (int n = 0; n < NRAND; n++) begin
      drive($urandom, $urandom, 1'($urandom));
      chk_all("R2 random");
    end

    // full propagate: R3
    for (int c = 0; c < 2; c++) begin
      drive(32'hFFFF_FFFF, 32'h0, c[0]);
      chk_all("R3 propagate");
    end

    // boundary carries between slices: R4 R5
    for (int s = 0; s < 6; s++) begin
      drive(32'((64'd1 << (4*s + 4)) - 1), 32'd1, 1'b0);
      chk_all("R4 slice_cross");
      drive(32'(4'hF << (4*s)), 32'(4'h1 << (4*s)), 1'b0);
      chk_all("R5 group_gen");
    end

    // all ones plus carry-in, padded top groups: R7
    drive(32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
    chk_all("R7 ones_plus_one");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    chk_all("R7 ones_ones_cin");
    drive(32'h0020_0000, 32'h0020_0000, 1'b0);
    chk("R7 top_bit22", 22, 32'(s22), c22);

    summary();
  end
endmodule